// File: doc/BRIEF.md
# Double-Buffered Four-Channel DAC Setpoint Registers

This block sits between a simple synchronous host bus and four 12-bit digital-to-analog converters. The host stages each channel's setpoint as two byte writes: a low byte and a high nibble. Staged values stay hidden from the converters. A read of a dedicated load offset copies all four staged codes into the output registers on a single clock edge, so every channel changes at the same moment.

A control register holds one enable bit. While that bit is clear, every presented code is held at zero, but the output registers keep their contents. The intended startup order is to zero the staging registers, issue a load read, and then set the enable bit.

The bus has separate write and read address ports, so a staging write and a load read can land in the same cycle. Codes are unsigned binary: 0x000 is the lowest output, 0x800 is mid-scale and 0xFFF is one step below full scale.

Top module: `dac_stage_regs`

## Requirements
- R1: After reset, every channel's presented code is 0 and the enable bit reads back 0.
- R2: A write to offset 2n (n = 0..3) stores wrData[7:0] as bits 7:0 of channel n's staged code. A write to offset 2n+1 stores wrData[3:0] as bits 11:8, and wrData[7:4] of that write is ignored.
- R3: A staging write never changes any presented code or output register by itself.
- R4: A read with rdAddr = 8 copies all four staged codes into the output registers at that clock edge. The new codes appear at the ports right after that edge.
- R5: The two staging writes of a channel may arrive in either order and give the same result.
- R6: A write to offset 9 sets the enable bit to wrData[0]. A read of offset 9 returns {7'b0, enable} combinationally in the same cycle.
- R7: While the enable bit is 0, all presented codes are 0. The output registers are retained and reappear when the bit is set again.
- R8: A write to offset 8, and any write or read at offsets 10 to 15, changes no register.
- R9: When a staging write and a load read happen in the same cycle, the load transfers the staged values from before that write. The write still takes effect in the staging register.
- R10: Channel n's code is presented on dacCode[12n+11:12n] as unsigned binary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 4 | Write offset |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | 4 | Read offset |
| rdData | output | 8 | Read data (enable readback; any value on a load read) |
| dacCode | output | 48 | Presented codes, channel n at bits 12n+11:12n |
| dacEnable | output | 1 | Output enable flag |

## Verification
A corrupted staged value stays invisible until the next load read. The bench therefore follows writes with frequent loads, so a staging fault shows on dacCode one edge after the load. A wrong output register or enable bit shows on the ports at the very next edge, because codes and enable are compared after every cycle. Same-cycle write and load pairs expose an off-by-one-cycle transfer at once. Disable and re-enable cycles expose output registers that are wrongly cleared while the enable bit is low.

// File: rtl/dacreg_pkg.sv
package dacreg_pkg;
  localparam int CH_COUNT = 4;

  typedef struct packed {
    logic [CH_COUNT-1:0] wrLo;
    logic [CH_COUNT-1:0] wrHi;
    logic                wrCtrl;
    logic                rdCtrl;
    logic                load;
  } strobe_t;
endpackage

// File: rtl/dac_ctrl.sv
module dac_ctrl
  import dacreg_pkg::*;
#(
  parameter int NUM_CH = CH_COUNT,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output strobe_t           str
);
  localparam int LOAD_OFF = 2 * NUM_CH;
  localparam int CTRL_OFF = LOAD_OFF + 1;

  always_comb begin
    str = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      str.wrLo[n] = wrEn && (wrAddr == ADDR_W'(2 * n));
      str.wrHi[n] = wrEn && (wrAddr == ADDR_W'(2 * n + 1));
    end
    str.wrCtrl = wrEn && (wrAddr == ADDR_W'(CTRL_OFF));
    str.rdCtrl = rdEn && (rdAddr == ADDR_W'(CTRL_OFF));
    str.load   = rdEn && (rdAddr == ADDR_W'(LOAD_OFF));
  end

  // R8: one write address selects at most one register
  assert_one_write_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({str.wrLo, str.wrHi, str.wrCtrl}));
  // R8: writes to offset 8 and above 9 raise no write strobe
  assert_no_stray_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrAddr >= ADDR_W'(LOAD_OFF) && wrAddr != ADDR_W'(CTRL_OFF))
      |-> (str.wrLo == '0 && str.wrHi == '0 && !str.wrCtrl));
endmodule

// File: rtl/dac_datapath.sv
module dac_datapath
  import dacreg_pkg::*;
#(
  parameter int NUM_CH = CH_COUNT,
  parameter int CODE_W = 12,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  strobe_t                  str,
  input  logic [BYTE_W-1:0]        wrData,
  output logic [BYTE_W-1:0]        rdData,
  output logic [NUM_CH*CODE_W-1:0] dacCode,
  output logic                     dacEnable
);
  localparam int LO_W = BYTE_W;
  localparam int HI_W = CODE_W - BYTE_W;

  logic [CODE_W-1:0] stageReg [NUM_CH];
  logic [CODE_W-1:0] outReg   [NUM_CH];
  logic              enReg;

  always_ff @(posedge clk) begin
    if (!rst_n)          enReg <= 1'b0;
    else if (str.wrCtrl) enReg <= wrData[0];
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stageReg[n] <= '0;
      end else begin
        if (str.wrLo[n]) stageReg[n][LO_W-1:0]      <= wrData;
        if (str.wrHi[n]) stageReg[n][CODE_W-1:LO_W] <= wrData[HI_W-1:0];
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)        outReg[n] <= '0;
      else if (str.load) outReg[n] <= stageReg[n];
    end

    assign dacCode[n*CODE_W +: CODE_W] = enReg ? outReg[n] : '0;

    // R2: high-part write lands in the upper bits only
    assert_hi_nibble_R2: assert property (@(posedge clk) disable iff (!rst_n)
      str.wrHi[n] |=> stageReg[n][CODE_W-1:LO_W] == $past(wrData[HI_W-1:0]));
    // R3: without a load the output register holds
    assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !str.load |=> $stable(outReg[n]));
    // R4 and R9: a load takes the staged value from before the edge
    assert_load_old_stage_R9: assert property (@(posedge clk) disable iff (!rst_n)
      str.load |=> outReg[n] == $past(stageReg[n]));
    // R8: with no write strobe the staging register holds
    assert_stage_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!str.wrLo[n] && !str.wrHi[n]) |=> $stable(stageReg[n]));
  end

  assign dacEnable = enReg;
  assign rdData    = str.rdCtrl ? {{(BYTE_W-1){1'b0}}, enReg} : '0;

  // R6: the enable bit follows bit 0 of a control write
  assert_enable_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    str.wrCtrl |=> dacEnable == $past(wrData[0]));
  // R7: the enable bit changes only through a control write
  assert_enable_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !str.wrCtrl |=> $stable(dacEnable));
endmodule

// File: rtl/dac_stage_regs.sv
module dac_stage_regs
  import dacreg_pkg::*;
#(
  parameter int NUM_CH = CH_COUNT,
  parameter int CODE_W = 12,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wrEn,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic [BYTE_W-1:0]        wrData,
  input  logic                     rdEn,
  input  logic [ADDR_W-1:0]        rdAddr,
  output logic [BYTE_W-1:0]        rdData,
  output logic [NUM_CH*CODE_W-1:0] dacCode,
  output logic                     dacEnable
);
  strobe_t str;

  dac_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr),
    .rdEn(rdEn), .rdAddr(rdAddr), .str(str)
  );

  dac_datapath #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .str(str), .wrData(wrData),
    .rdData(rdData), .dacCode(dacCode), .dacEnable(dacEnable)
  );
endmodule

// File: tb/tb_dac_stage_regs.sv
module tb_dac_stage_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [3:0]  wrAddr = '0, rdAddr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [47:0] dacCode;
  logic        dacEnable;

  int checks = 0, fails = 0;
  logic [11:0] mStage [4];
  logic [11:0] mOut   [4];
  logic        mEn;

  always #2 clk = ~clk;

  dac_stage_regs dut (.*);

  function automatic logic [11:0] expCode(int n);
    return mEn ? mOut[n] : 12'h000;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    for (int n = 0; n < 4; n++) check(tag, 64'(dacCode[n*12 +: 12]), 64'(expCode(n)));
    check(tag, 64'(dacEnable), 64'(mEn));
  endtask

  // One bus cycle: drive at negedge, update the model at the edge, compare after it
  task automatic cyc(string tag, logic we, logic [3:0] wa, logic [7:0] wd,
                     logic re, logic [3:0] ra);
    logic [11:0] old [4];
    @(negedge clk);
    wrEn = we; wrAddr = wa; wrData = wd; rdEn = re; rdAddr = ra;
    #1;
    if (re && ra == 4'd9) check({tag, " R6 readback"}, 64'(rdData), 64'({7'b0, mEn}));
    @(posedge clk);
    for (int n = 0; n < 4; n++) old[n] = mStage[n];
    if (we) begin
      if (wa < 4'd8 && !wa[0]) mStage[wa >> 1][7:0]  = wd;
      if (wa < 4'd8 &&  wa[0]) mStage[wa >> 1][11:8] = wd[3:0];
      if (wa == 4'd9)          mEn = wd[0];
    end
    if (re && ra == 4'd8) for (int n = 0; n < 4; n++) mOut[n] = old[n];
    #1;
    wrEn = 1'b0; rdEn = 1'b0;
    checkAll(tag);
  endtask

  task automatic wr(string tag, logic [3:0] a, logic [7:0] d);
    cyc(tag, 1'b1, a, d, 1'b0, 4'd0);
  endtask

  task automatic load(string tag);
    cyc(tag, 1'b0, 4'd0, 8'd0, 1'b1, 4'd8);
  endtask

  initial begin
    #150000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int n = 0; n < 4; n++) begin mStage[n] = '0; mOut[n] = '0; end
    mEn = 1'b0;
    repeat (3) @(posedge clk);
    #1 checkAll("R1 reset");
    @(negedge clk) rst_n = 1'b1;
    cyc("R1 idle", 1'b0, 4'd0, 8'd0, 1'b1, 4'd9);

    // startup order: zero, load, enable
    for (int a = 0; a < 8; a++) wr("R2 zero", 4'(a), 8'h00);
    load("R4 zero load");
    wr("R6 enable", 4'd9, 8'h01);
    cyc("R6 read enable", 1'b0, 4'd0, 8'd0, 1'b1, 4'd9);

    // R2 and R10: upper write bits ignored; R3: no output change before load
    wr("R2 ch0 lo", 4'd0, 8'hFF);
    wr("R2 ch0 hi", 4'd1, 8'hAF);
    wr("R3 ch3 hi", 4'd7, 8'h58);
    wr("R5 ch1 hi first", 4'd3, 8'h08);
    wr("R5 ch1 lo second", 4'd2, 8'h00);
    wr("R5 ch2 lo first", 4'd4, 8'h00);
    wr("R5 ch2 hi second", 4'd5, 8'h08);
    load("R4 R10 load");
    check("R5 both orders give 0x800", 64'(dacCode[12 +: 12]), 64'(dacCode[24 +: 12]));
    check("R10 ch0 full code", 64'(dacCode[11:0]), 64'h0FFF);

    // R8: write to load offset and undecoded offsets
    wr("R8 write load offset", 4'd8, 8'hFF);
    for (int a = 10; a < 16; a++) cyc("R8 undecoded", 1'b1, 4'(a), 8'hFF, 1'b1, 4'(a));
    load("R8 stage unchanged");

    // R9: same-cycle write and load
    wr("R9 prep", 4'd6, 8'h11);
    cyc("R9 same cycle", 1'b1, 4'd6, 8'h22, 1'b1, 4'd8);
    load("R9 second load");

    // R7: disable zeroes codes, re-enable restores retained codes
    wr("R7 disable", 4'd9, 8'hFE);
    wr("R7 stage while off", 4'd0, 8'h5A);
    wr("R7 enable", 4'd9, 8'h01);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] wa, ra;
      logic we, re;
      wa = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 3) == 0) wa = 4'd9;
      ra = ($urandom_range(0, 1) == 0) ? 4'd8 : 4'($urandom_range(0, 15));
      we = 1'($urandom_range(0, 1));
      re = ($urandom_range(0, 2) == 0);
      cyc("R2 R4 R9 random", we, wa, 8'($urandom_range(0, 255)), re, ra);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule